// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block takes level changes from seven interrupt request sources and routes each one to one of six output lines through six routing entries. Every entry is a 64-bit register that software can read and write through a small indexed register port. It holds a destination server, a priority, an output-line (source) number and a pending flag. Requests 0 and 1 share entry 0. Requests 2 to 6 each own one of entries 1 to 5. Each request also keeps a status bit that software can read: requests 0 and 1 report in a control word, and requests 2 to 6 report in a status word.

Level changes arrive as one event per cycle, carrying a request number and the new level. The block updates the status bit and recomputes the pending flag of the entry that was hit. Each output line is the OR of the activity of every entry whose source field selects that line. When software writes a routing entry, the block issues a one-cycle configuration strobe toward the downstream presentation logic. The strobe carries the selected line, the effective server and the priority.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, every entry has server 0, priority 0xFF, pending 0, and a source field equal to its ordinal: index 0x10 holds 0, and indices 0x16..0x1A hold 1..5. All status bits and all output lines are 0.
- R2: A routing entry reads as server in bits 55:40, priority in 39:32, source in 31:29 and pending in bit 24, with all other bits 0. A write replaces server, priority and source, and keeps the pending flag unless the new priority is 0xFF.
- R3: An entry with priority 0xFF is masked. On an event, pending becomes (entry active AND not masked). A write that sets priority 0xFF clears pending. A write that unmasks does not set pending until the next event.
- R4: Request 0 is reported in bit 47 and request 1 in bit 46 of the word at index 0x0E. Requests 2..6 are reported in bits 36..32 of the word at index 0x15, in that order. Both words ignore writes.
- R5: Entry 0 is active while request 0 or request 1 is high. Lowering one of them while the other stays high leaves the entry's line and pending flag set.
- R6: Output line k is high one cycle after an event whenever any entry whose source field equals k is active, whatever that entry's priority. An entry whose source field is 6 or 7 drives no line.
- R7: One cycle after a write to a routing entry whose new source is below 6, cfg_valid pulses for one cycle. It carries cfg_line = source, cfg_server = server field shifted right by 2, and cfg_prio = priority. A source of 6 or 7 produces no strobe.
- R8: An event with request number 7 changes no status bit and raises evt_err for exactly one cycle, one cycle later.
- R9: A read of any index other than 0x0E, 0x15, 0x10 or 0x16..0x1A returns all ones. Read data appears with rd_valid one cycle after reg_rd.
- R10: When a write and an event hit the same entry in one cycle, the fields come from the write, and pending is computed from the event using the newly written priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Level-change event present |
| evt_id | input | 3 | Request number of the event |
| evt_level | input | 1 | New level of the request |
| evt_err | output | 1 | Pulse for an unsupported request number |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| irq_line | output | 6 | Routed interrupt output lines |
| cfg_valid | output | 1 | Entry configuration strobe |
| cfg_line | output | 3 | Line selected by the written entry |
| cfg_server | output | 14 | Effective destination server |
| cfg_prio | output | 8 | Written priority |

## Verification
A software write to a routing entry and a level event for the same entry can land in the same cycle. Both then update the same pending flag, and the write also changes the mask that the event's pending computation depends on. The bench drives reg_we and evt_valid together on one entry twice: once with an unmasking priority and once with priority 0xFF. After each, it reads the entry back. The read must show the written fields, with pending set only in the unmasked case. A second overlap sits inside the shared entry, where one request drops while the other is still high. There the line and pending flag must hold.

// File: rtl/irq_route_pkg.sv
// Package: field layout of a routing entry, register indices and helpers
// shared by the router modules. Field positions are decoded by software.
package irq_route_pkg;
    localparam int XW       = 64;
    localparam int IDXW     = 5;
    localparam int SRV_HI   = 55;
    localparam int SRV_LO   = 40;
    localparam int PRI_HI   = 39;
    localparam int PRI_LO   = 32;
    localparam int SRC_HI   = 31;
    localparam int SRC_LO   = 29;
    localparam int PEND_BIT = 24;
    localparam int SRVW     = SRV_HI - SRV_LO + 1;
    localparam int PRIW     = PRI_HI - PRI_LO + 1;
    localparam int SRCW     = SRC_HI - SRC_LO + 1;
    localparam int LINK_W   = 2;
    localparam int EFF_SRVW = SRVW - LINK_W;

    localparam logic [PRIW-1:0] PRI_MASKED = '1;

    localparam logic [IDXW-1:0] IDX_CTRL   = 5'h0E;
    localparam logic [IDXW-1:0] IDX_SHARED = 5'h10;
    localparam logic [IDXW-1:0] IDX_STAT   = 5'h15;

    localparam int CTRL_BIT_A = 47;
    localparam int CTRL_BIT_B = 46;
    localparam int STAT_TOP   = 36;

    typedef struct packed {
        logic [SRVW-1:0] server;
        logic [PRIW-1:0] prio;
        logic [SRCW-1:0] src;
        logic            pend;
    } route_t;

    // Register index of routing entry e (entry 0 is the shared one).
    function automatic logic [IDXW-1:0] entry_idx(input int e);
        return (e == 0) ? IDX_SHARED : IDX_STAT + IDXW'(e);
    endfunction

    // Place an entry into its 64-bit register image.
    function automatic logic [XW-1:0] pack_route(input route_t r);
        logic [XW-1:0] v;
        v = '0;
        v[SRV_HI:SRV_LO] = r.server;
        v[PRI_HI:PRI_LO] = r.prio;
        v[SRC_HI:SRC_LO] = r.src;
        v[PEND_BIT]      = r.pend;
        return v;
    endfunction
endpackage

// File: rtl/irq_route_status.sv
// Module: request status bank.
// Holds one status bit per request, applies one level event per cycle,
// and reports per entry whether it is hit and whether it is active now and
// after the event. Assumes N_ENT = N_REQ - 1, with requests 0 and 1 sharing
// entry 0. Request numbers at or above N_REQ are dropped and flagged.
module irq_route_status #(
    parameter int N_REQ = 7,
    parameter int N_ENT = N_REQ - 1,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [ID_W-1:0]  evt_id,
    input  logic             evt_level,
    output logic [N_REQ-1:0] stat,
    output logic [N_ENT-1:0] ent_hit,
    output logic [N_ENT-1:0] ent_act,
    output logic [N_ENT-1:0] ent_act_next,
    output logic             evt_err
);
    logic [N_REQ-1:0] stat_nxt;
    logic             id_ok;

    // Purpose: decide whether the event names a supported request.
    assign id_ok = evt_valid && (32'(evt_id) < N_REQ);

    // Purpose: next status vector after applying the event.
    always_comb begin
        stat_nxt = stat;
        for (int i = 0; i < N_REQ; i++)
            if (id_ok && (32'(evt_id) == i)) stat_nxt[i] = evt_level;
    end

    // Purpose: register status bits and the unsupported-number pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat    <= '0;
            evt_err <= 1'b0;
        end else begin
            stat    <= stat_nxt;
            evt_err <= evt_valid && !id_ok;
        end
    end

    // Entry 0 merges requests 0 and 1; entry e>0 follows request e+1.
    for (genvar e = 0; e < N_ENT; e++) begin : g_map
        if (e == 0) begin : g_shared
            assign ent_hit[e]      = id_ok && (32'(evt_id) <= 1);
            assign ent_act[e]      = stat[0] | stat[1];
            assign ent_act_next[e] = stat_nxt[0] | stat_nxt[1];
        end else begin : g_single
            assign ent_hit[e]      = id_ok && (32'(evt_id) == e + 1);
            assign ent_act[e]      = stat[e+1];
            assign ent_act_next[e] = stat_nxt[e+1];
        end
    end

    a_r8_bad_id_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (32'(evt_id) >= N_REQ)) |=> ($stable(stat) && evt_err));
    a_r8_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid) |=> !evt_err);
endmodule

// File: rtl/irq_route_entry.sv
// Module: one routing entry.
// Holds server, priority, source and pending. A write replaces the three
// fields; an event recomputes pending from activity and the (possibly newly
// written) priority. Assumes at most one write and one event per cycle.
module irq_route_entry
    import irq_route_pkg::*;
#(
    parameter int ORDINAL = 0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  route_t wr_val,
    input  logic   evt_en,
    input  logic   act_next,
    output route_t ent
);
    route_t nxt;
    logic   masked;

    // Purpose: merge write fields, then derive pending with the new mask.
    always_comb begin
        nxt = ent;
        if (wr_en) begin
            nxt.server = wr_val.server;
            nxt.prio   = wr_val.prio;
            nxt.src    = wr_val.src;
        end
        masked = (nxt.prio == PRI_MASKED);
        if (evt_en)     nxt.pend = act_next && !masked;
        else if (wr_en) nxt.pend = ent.pend && !masked;
    end

    // Purpose: entry state register with masked reset image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent.server <= '0;
            ent.prio   <= PRI_MASKED;
            ent.src    <= SRCW'(ORDINAL);
            ent.pend   <= 1'b0;
        end else begin
            ent <= nxt;
        end
    end

    a_r3_masked_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ent.prio == PRI_MASKED) |-> !ent.pend);
    a_r2_write_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !evt_en && (wr_val.prio != PRI_MASKED)) |=> (ent.pend == $past(ent.pend)));
    a_r10_write_fields_win: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && evt_en) |=> (ent.prio == $past(wr_val.prio) && ent.src == $past(wr_val.src)));
endmodule

// File: rtl/irq_route_lines.sv
// Module: output line fan-in.
// Line k is the OR of the activity of every entry whose source field is k.
// Source values at or above N_ENT select no line. Pure combinational.
module irq_route_lines #(
    parameter int N_ENT = 6,
    parameter int SRCW  = 3
) (
    input  logic [N_ENT*SRCW-1:0] src_flat,
    input  logic [N_ENT-1:0]      act,
    output logic [N_ENT-1:0]      line
);
    for (genvar k = 0; k < N_ENT; k++) begin : g_line
        // Purpose: collect every active entry that points at line k.
        always_comb begin
            line[k] = 1'b0;
            for (int e = 0; e < N_ENT; e++)
                if (act[e] && (32'(src_flat[e*SRCW +: SRCW]) == k)) line[k] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_route_hub.sv
// Module: vectored interrupt source router, top level.
// Decodes the indexed register port, hosts the status bank, the routing
// entries and the line fan-in, and emits the configuration strobe after a
// routing write. Reads are registered; writes take effect at the next edge.
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int N_REQ = 7,
    parameter int ID_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [ID_W-1:0]     evt_id,
    input  logic                evt_level,
    output logic                evt_err,
    input  logic                reg_we,
    input  logic                reg_rd,
    input  logic [IDXW-1:0]     reg_idx,
    input  logic [XW-1:0]       reg_wdata,
    output logic                rd_valid,
    output logic [XW-1:0]       rd_data,
    output logic [N_REQ-2:0]    irq_line,
    output logic                cfg_valid,
    output logic [SRCW-1:0]     cfg_line,
    output logic [EFF_SRVW-1:0] cfg_server,
    output logic [PRIW-1:0]     cfg_prio
);
    localparam int N_ENT = N_REQ - 1;

    logic [N_REQ-1:0]      stat;
    logic [N_ENT-1:0]      ent_hit, ent_act, ent_act_next, wr_hit;
    logic [N_ENT*SRCW-1:0] src_flat;
    route_t                ent [N_ENT];
    route_t                wr_val;
    logic [XW-1:0]         rd_mux;
    logic                  rd_mapped;
    logic                  any_wr;
    logic                  unused_wbits;

    // Purpose: extract the writable fields from write data.
    always_comb begin
        wr_val.server = reg_wdata[SRV_HI:SRV_LO];
        wr_val.prio   = reg_wdata[PRI_HI:PRI_LO];
        wr_val.src    = reg_wdata[SRC_HI:SRC_LO];
        wr_val.pend   = 1'b0;
    end
    assign unused_wbits = ^{reg_wdata[XW-1:SRV_HI+1], reg_wdata[SRC_LO-1:0]};

    irq_route_status #(.N_REQ(N_REQ), .N_ENT(N_ENT), .ID_W(ID_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_id(evt_id), .evt_level(evt_level),
        .stat(stat), .ent_hit(ent_hit), .ent_act(ent_act),
        .ent_act_next(ent_act_next), .evt_err(evt_err)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign wr_hit[e] = reg_we && (reg_idx == entry_idx(e));
        irq_route_entry #(.ORDINAL(e)) u_entry (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_hit[e]), .wr_val(wr_val),
            .evt_en(ent_hit[e]), .act_next(ent_act_next[e]),
            .ent(ent[e])
        );
        assign src_flat[e*SRCW +: SRCW] = ent[e].src;
    end

    irq_route_lines #(.N_ENT(N_ENT), .SRCW(SRCW)) u_lines (
        .src_flat(src_flat), .act(ent_act), .line(irq_line)
    );

    assign any_wr = |wr_hit;

    // Purpose: configuration strobe one cycle after a supported routing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid  <= 1'b0;
            cfg_line   <= '0;
            cfg_server <= '0;
            cfg_prio   <= '0;
        end else begin
            cfg_valid <= any_wr && (32'(wr_val.src) < N_ENT);
            if (any_wr) begin
                cfg_line   <= wr_val.src;
                cfg_server <= wr_val.server[SRVW-1:LINK_W];
                cfg_prio   <= wr_val.prio;
            end
        end
    end

    // Purpose: select the register image for a read index.
    always_comb begin
        rd_mux    = '1;
        rd_mapped = 1'b0;
        if (reg_idx == IDX_CTRL) begin
            rd_mux             = '0;
            rd_mux[CTRL_BIT_A] = stat[0];
            rd_mux[CTRL_BIT_B] = stat[1];
            rd_mapped          = 1'b1;
        end
        if (reg_idx == IDX_STAT) begin
            rd_mux = '0;
            for (int i = 2; i < N_REQ; i++) rd_mux[STAT_TOP-(i-2)] = stat[i];
            rd_mapped = 1'b1;
        end
        for (int e = 0; e < N_ENT; e++)
            if (reg_idx == entry_idx(e)) begin
                rd_mux    = pack_route(ent[e]);
                rd_mapped = 1'b1;
            end
    end

    // Purpose: registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= reg_rd;
            if (reg_rd) rd_data <= rd_mux;
        end
    end

    a_r9_unmapped_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rd_mapped) |=> (rd_valid && rd_data == '1));
    a_r7_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && (32'(wr_val.src) < N_ENT)) |=> (cfg_valid && cfg_prio == $past(wr_val.prio)));
    a_r7_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we) |=> !cfg_valid);
    a_r6_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> (irq_line == '0));
    a_r5_shared_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_id == '0 && !evt_level && stat[1] && !wr_hit[0]
         && (32'(ent[0].src) < N_ENT)) |=> irq_line[ent[0].src]);
endmodule

// File: tb/irq_route_hub_tb.sv
module irq_route_hub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0, evt_level = 1'b0;
    logic [2:0]  evt_id = '0;
    logic        evt_err;
    logic        reg_we = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [5:0]  irq_line;
    logic        cfg_valid;
    logic [2:0]  cfg_line;
    logic [13:0] cfg_server;
    logic [7:0]  cfg_prio;

    int checks = 0, errors = 0, cycles = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    irq_route_hub u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
        .evt_level(evt_level), .evt_err(evt_err), .reg_we(reg_we), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_line(irq_line), .cfg_valid(cfg_valid), .cfg_line(cfg_line),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rv(int s, int p, int src, int pend);
        return (64'(s) << 40) | (64'(p) << 32) | (64'(src) << 29) | (64'(pend) << 24);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses come out.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) chk("R9 unexpected read", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_read(logic [4:0] idx, logic [63:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); reg_rd = 1'b1; reg_idx = idx;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic do_write(logic [4:0] idx, logic [63:0] d);
        @(negedge clk); reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic do_evt(int id, logic lvl);
        @(negedge clk); evt_valid = 1'b1; evt_id = 3'(id); evt_level = lvl;
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic do_both(logic [4:0] idx, logic [63:0] d, int id, logic lvl);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        evt_valid = 1'b1; evt_id = 3'(id); evt_level = lvl;
        @(negedge clk); reg_we = 1'b0; evt_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset image
        chk("R1 lines after reset", 64'(irq_line), 64'd0);
        do_read(5'h10, rv(0, 8'hFF, 0, 0), "R1 entry 0x10");
        for (int e = 1; e < 6; e++) do_read(5'(8'h15 + e), rv(0, 8'hFF, e, 0), "R1 entry ordinal");
        do_read(5'h15, 64'd0, "R1 status word");
        do_read(5'h0E, 64'd0, "R1 control word");

        // R2/R7 write with junk bits, pending untouched
        do_write(5'h10, rv(16'h0135, 8'h05, 3, 1) | 64'hFF00_0000_0000_0001);
        chk("R7 strobe valid", 64'(cfg_valid), 64'd1);
        chk("R7 strobe line", 64'(cfg_line), 64'd3);
        chk("R7 strobe server", 64'(cfg_server), 64'h4D);
        chk("R7 strobe prio", 64'(cfg_prio), 64'h05);
        @(negedge clk);
        chk("R7 strobe one cycle", 64'(cfg_valid), 64'd0);
        do_read(5'h10, rv(16'h0135, 8'h05, 3, 0), "R2 entry fields");

        // R3/R4/R6 request 0 raises line 3 and pending
        do_evt(0, 1'b1);
        chk("R6 line 3 from entry 0", 64'(irq_line), 64'b001000);
        do_read(5'h0E, 64'h0000_8000_0000_0000, "R4 request 0 bit 47");
        do_read(5'h10, rv(16'h0135, 8'h05, 3, 1), "R3 pending set");

        // R5 shared entry
        do_evt(1, 1'b1);
        do_evt(0, 1'b0);
        chk("R5 shared line held", 64'(irq_line), 64'b001000);
        do_read(5'h10, rv(16'h0135, 8'h05, 3, 1), "R5 shared pending held");
        do_read(5'h0E, 64'h0000_4000_0000_0000, "R4 request 1 bit 46");
        do_evt(1, 1'b0);
        chk("R5 shared line drops", 64'(irq_line), 64'd0);
        do_read(5'h10, rv(16'h0135, 8'h05, 3, 0), "R5 shared pending drops");

        // R3/R6 masked entry still drives its line but not pending
        do_evt(2, 1'b1);
        chk("R6 masked entry drives line 1", 64'(irq_line), 64'b000010);
        do_read(5'h15, 64'h0000_0010_0000_0000, "R4 request 2 bit 36");
        do_read(5'h16, rv(0, 8'hFF, 1, 0), "R3 masked no pending");
        do_write(5'h16, rv(0, 8'h10, 1, 0));
        do_read(5'h16, rv(0, 8'h10, 1, 0), "R3 unmask does not set pending");
        do_evt(2, 1'b1);
        do_read(5'h16, rv(0, 8'h10, 1, 1), "R3 event sets pending");
        do_write(5'h16, rv(16'h0008, 8'h20, 1, 0));
        do_read(5'h16, rv(16'h0008, 8'h20, 1, 1), "R2 write keeps pending");
        do_write(5'h16, rv(16'h0008, 8'hFF, 1, 0));
        do_read(5'h16, rv(16'h0008, 8'hFF, 1, 0), "R3 mask write clears pending");
        do_evt(2, 1'b0);

        // R6/R7 unsupported source
        do_evt(6, 1'b1);
        chk("R6 request 6 on line 5", 64'(irq_line), 64'b100000);
        do_read(5'h15, 64'h0000_0001_0000_0000, "R4 request 6 bit 32");
        do_write(5'h1A, rv(0, 8'h01, 7, 0));
        chk("R7 no strobe for source 7", 64'(cfg_valid), 64'd0);
        chk("R6 source 7 drives no line", 64'(irq_line), 64'd0);
        do_evt(6, 1'b0);

        // R8 unsupported request number
        do_evt(7, 1'b1);
        chk("R8 error pulse", 64'(evt_err), 64'd1);
        @(negedge clk);
        chk("R8 error one cycle", 64'(evt_err), 64'd0);
        do_read(5'h15, 64'd0, "R8 status word unchanged");
        do_read(5'h0E, 64'd0, "R8 control word unchanged");

        // R4 read-only words, R9 unmapped index
        do_write(5'h15, '1);
        do_write(5'h0E, '1);
        do_read(5'h15, 64'd0, "R4 status ignores write");
        do_read(5'h0E, 64'd0, "R4 control ignores write");
        do_read(5'h03, '1, "R9 unmapped reads ones");

        // R10 write and event on the same entry in one cycle
        do_both(5'h17, rv(16'h0004, 8'h07, 2, 0), 3, 1'b1);
        chk("R10 strobe line", 64'(cfg_line), 64'd2);
        chk("R10 line 2 active", 64'(irq_line), 64'b000100);
        do_read(5'h17, rv(16'h0004, 8'h07, 2, 1), "R10 unmasked pending");
        do_both(5'h17, rv(16'h0004, 8'hFF, 2, 0), 3, 1'b1);
        do_read(5'h17, rv(16'h0004, 8'hFF, 2, 0), "R10 masked by same-cycle write");

        repeat (3) @(negedge clk);
        chk("R9 all reads answered", 64'(exp_q.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule